// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execution unit of a pipelined 32-bit processor. It computes one of nine operations on its sources in the same cycle: add, add with carry-in, subtract, subtract with carry-in, AND, OR, XOR, logical shift and arithmetic shift. It also drives the negative, zero, carry and overflow flags that describe the result. A composite mode chains two operations. The inner operation combines the second and third sources, and the outer operation combines the first source with that intermediate value. The flags always describe the outer step.

Shifts take a signed amount from the low six bits of the second source. A non-negative amount shifts left and a negative amount shifts right by its magnitude. The block also holds the 32-bit processor status word in a register. That word changes only when the instruction asks for a flag update or names the status word as its destination. When both happen, the result is written first and the flag bits are then overwritten with the flags of that result.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 gives a+b and code 1 gives a+b+carry_in, both modulo 2^32.
- R2: Code 2 gives a-b and code 3 gives a-b-1+carry_in, both modulo 2^32, so carry_in acts as an inverted borrow.
- R3: Code 4 gives a AND b, code 5 gives a OR b and code 6 gives a XOR b. These three, the shifts (7 and 8) and the unused codes 9 to 15 all force flag_c and flag_v to 0. The unused codes also give a result of 0.
- R4: For code 7 (logical shift) and code 8 (arithmetic shift), an amount from 0 to 31 shifts a left by that amount and fills the low bits with zero.
- R5: An amount from -1 to -31 shifts a right by its magnitude. Code 7 fills the vacated bits with zero and code 8 fills them with copies of bit 31.
- R6: The shift amount is bits [5:0] of b read as two's complement, and bits [31:6] are ignored, so 0xFFFFFFFC means -4. An amount of -32 gives a result of 0.
- R7: flag_n equals result bit 31, and flag_z is 1 exactly when the result is 0.
- R8: For codes 0 to 3, flag_c is the carry out of the 32-bit sum (for subtraction, 1 means no borrow) and flag_v is 1 on two's-complement overflow.
- R9: When neither set_flags nor dest_status is high, status_q keeps its value across the clock edge.
- R10: When only set_flags is high, status_q bits [3:0] take {N,Z,C,V} (N at bit 3, V at bit 0) at the next edge, and bits [31:4] keep their value.
- R11: When only dest_status is high, status_q takes the full result at the next edge.
- R12: When both are high, status_q bits [31:4] take result bits [31:4] and bits [3:0] take {N,Z,C,V}.
- R13: When compose is high, result = a OPo (b OPi c), using the outer code op_outer and the inner code op_inner, with carry_in used by both steps and the flags taken from the outer step. When compose is low, result = a OPo b.
- R14: While rst_n is low, status_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_outer | input | 4 | Operation code of the outer (or only) step |
| op_inner | input | 4 | Operation code of the inner step in composite mode |
| compose | input | 1 | Selects the chained three-source form |
| src_a | input | 32 | First source |
| src_b | input | 32 | Second source; its low six bits are the shift amount |
| src_c | input | 32 | Third source, used only in composite mode |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Instruction requests a flag update |
| dest_status | input | 1 | Destination is the status word |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Overflow flag |
| status_q | output | 32 | Registered status word |

## Verification
The result and the four flags depend only on the current inputs and are due in the same cycle. The bench therefore drives the inputs on the falling edge and compares these outputs one time unit later, well before the next rising edge. status_q is due one rising edge after the inputs that change it. It is compared one time unit after that edge against a model word that the bench updates with the same rule. The sweeps cover every operation code against pairs of corner operands, every shift amount from -32 to 31 with and without junk in the upper bits of b, every pair of inner and outer codes in composite mode, and all four status-update modes in rotation.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_outer,
  input  logic [3:0]   op_inner,
  input  logic         compose,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_c,
  input  logic         carry_in,
  input  logic         set_flags,
  input  logic         dest_status,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic [W-1:0] status_q
);
  localparam int SHW = $clog2(W) + 1;
  localparam int FN = 3, FZ = 2, FC = 1, FV = 0;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_SH  = 4'd7,
                         OP_SHA = 4'd8;

  function automatic logic [W+1:0] step(input logic [3:0] op, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic ci);
    logic [W:0]     sum;
    logic [W-1:0]   bx, r;
    logic           cx, c, v;
    logic [SHW-1:0] amt, mag;
    r   = '0;
    c   = 1'b0;
    v   = 1'b0;
    bx  = b;
    cx  = 1'b0;
    sum = '0;
    amt = b[SHW-1:0];
    mag = ~amt + {{(SHW-1){1'b0}}, 1'b1};
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        if (op == OP_SUB || op == OP_SBC) bx = ~b;
        cx  = (op == OP_SUB) ? 1'b1 : (op == OP_ADD) ? 1'b0 : ci;
        sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
        r   = sum[W-1:0];
        c   = sum[W];
        v   = (a[W-1] == bx[W-1]) && (r[W-1] != a[W-1]);
      end
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_SH, OP_SHA: begin
        if (!amt[SHW-1])
          r = a << amt;
        else if (amt == {1'b1, {(SHW-1){1'b0}}})
          r = '0;
        else if (op == OP_SHA)
          r = $signed(a) >>> mag;
        else
          r = a >> mag;
      end
      default: r = '0;
    endcase
    return {c, v, r};
  endfunction

  logic [W+1:0] inner_w, outer_w;

  assign inner_w = step(op_inner, src_b, src_c, carry_in);
  assign outer_w = step(op_outer, src_a, compose ? inner_w[W-1:0] : src_b, carry_in);
  assign result  = outer_w[W-1:0];
  assign flag_c  = outer_w[W+1];
  assign flag_v  = outer_w[W];
  assign flag_n  = result[W-1];
  assign flag_z  = (result == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      if (dest_status) status_q <= result;
      if (set_flags) begin
        status_q[FN] <= flag_n;
        status_q[FZ] <= flag_z;
        status_q[FC] <= flag_c;
        status_q[FV] <= flag_v;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !dest_status) |=> $stable(status_q));

  p_flags_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !dest_status) |=>
      (status_q[W-1:4] == $past(status_q[W-1:4])) &&
      (status_q[3:0] == $past({flag_n, flag_z, flag_c, flag_v})));

  p_dest_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_status && !set_flags) |=> (status_q == $past(result)));

  p_write_then_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_status && set_flags) |=>
      (status_q[W-1:4] == $past(result[W-1:4])) &&
      (status_q[3:0] == $past({flag_n, flag_z, flag_c, flag_v})));

  p_logic_cv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_outer >= OP_AND) |-> (!flag_c && !flag_v));

  p_shift_min_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!compose && (op_outer == OP_SH || op_outer == OP_SHA) &&
     src_b[SHW-1:0] == {1'b1, {(SHW-1){1'b0}}}) |-> (result == '0 && flag_z));
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_outer = 4'd0, op_inner = 4'd0;
  logic        compose = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic        carry_in = 1'b0, set_flags = 1'b0, dest_status = 1'b0;
  logic [31:0] result, status_q;
  logic        flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0, n_fail = 0;
  logic [31:0] stat_m = '0;
  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                            32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFFC, 32'h5};

  always #4 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_outer(op_outer), .op_inner(op_inner),
    .compose(compose), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .carry_in(carry_in), .set_flags(set_flags), .dest_status(dest_status),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .status_q(status_q));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int shamt(input logic [31:0] b);
    return b[5] ? int'(b[5:0]) - 64 : int'(b[5:0]);
  endfunction

  function automatic void mdl(input int op, input logic [31:0] a, input logic [31:0] b,
                              input bit ci, output logic [31:0] r, output bit c, output bit v);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint s, sv;
    int k;
    r = '0; c = 0; v = 0; sv = 0;
    case (op)
      0, 1: begin
        s  = ua + ub + ((op == 1) ? longint'(ci) : 0);
        sv = sa + sb + ((op == 1) ? longint'(ci) : 0);
        r  = 32'(s);
        c  = s > 64'hFFFFFFFF;
      end
      2, 3: begin
        s  = ua - ub - ((op == 3) ? 1 - longint'(ci) : 0);
        sv = sa - sb - ((op == 3) ? 1 - longint'(ci) : 0);
        r  = 32'(s);
        c  = s >= 0;
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7, 8: begin
        k = shamt(b);
        if (k >= 0) r = 32'(ua << k);
        else if (k == -32) r = '0;
        else if (op == 7) r = 32'(ua >> (-k));
        else r = 32'(sa >>> (-k));
      end
      default: r = '0;
    endcase
    if (op <= 3) v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
  endfunction

  task automatic apply(input int oo, input int oi, input bit comp, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c, input bit ci,
                       input int mode, input string rtag);
    logic [31:0] ri, r, st_tag_dummy;
    bit cc, vv, ci2, vi;
    logic [3:0] fl;
    string mt;
    @(negedge clk);
    op_outer = 4'(oo); op_inner = 4'(oi); compose = comp;
    src_a = a; src_b = b; src_c = c; carry_in = ci;
    set_flags = mode[0]; dest_status = mode[1];
    if (comp) begin
      mdl(oi, b, c, ci, ri, ci2, vi);
      mdl(oo, a, ri, ci, r, cc, vv);
    end else begin
      mdl(oo, a, b, ci, r, cc, vv);
    end
    #1;
    chk(rtag, "result", result, r);
    chk("R7", "flag_n", {31'b0, flag_n}, {31'b0, r[31]});
    chk("R7", "flag_z", {31'b0, flag_z}, {31'b0, r == 0});
    chk(oo <= 3 ? "R8" : "R3", "flag_c", {31'b0, flag_c}, {31'b0, cc});
    chk(oo <= 3 ? "R8" : "R3", "flag_v", {31'b0, flag_v}, {31'b0, vv});
    fl = {r[31], r == 0, cc, vv};
    st_tag_dummy = stat_m;
    case (mode)
      0: mt = "R9";
      1: begin mt = "R10"; stat_m = {st_tag_dummy[31:4], fl}; end
      2: begin mt = "R11"; stat_m = r; end
      default: begin mt = "R12"; stat_m = {r[31:4], fl}; end
    endcase
    @(posedge clk);
    #1;
    chk(mt, "status_q", status_q, stat_m);
  endtask

  function automatic string optag(input int op, input logic [31:0] b);
    int k;
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op <= 6 || op > 8) return "R3";
    k = shamt(b);
    if (k == -32) return "R6";
    return (k < 0) ? "R5" : "R4";
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R14", "status_q in reset", status_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int ci = 0; ci < 2; ci++)
            apply(op, 0, 1'b0, vals[ia], vals[ib], 32'h0, ci[0], (ia + ib + op + ci) % 4,
                  optag(op, vals[ib]));
    for (int op = 7; op < 9; op++)
      for (int ia = 0; ia < 4; ia++)
        for (int k = -32; k < 32; k++) begin
          logic [31:0] a, b;
          a = (ia == 0) ? 32'h80000001 : (ia == 1) ? 32'hDEADBEEF :
              (ia == 2) ? 32'h7FFFFFF0 : 32'hFFFFFFFF;
          b = 32'(k);
          apply(op, 0, 1'b0, a, b, 32'h0, 1'b0, (k + 64) % 4, optag(op, b));
          b = 32'hABCDE0C0 | (32'(k) & 32'h3F);
          apply(op, 0, 1'b0, a, b, 32'h0, 1'b1, (k + 65) % 4, "R6");
        end
    for (int oo = 0; oo < 9; oo++)
      for (int oi = 0; oi < 9; oi++)
        for (int j = 0; j < 6; j++)
          apply(oo, oi, 1'b1, vals[j], vals[j + 1], vals[j + 2], j[0], (oo + oi + j) % 4, "R13");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule